// File: doc/BRIEF.md
# Dual-Clock FIFO Programmable Status Flags

This block derives three active-low level flags for a FIFO whose writer and reader run on unrelated clocks: half-full, almost-full and almost-empty. It takes the writer's binary word pointer (write clock domain) and the reader's binary word pointer (read clock domain), and computes occupancy as their difference modulo the pointer range. Each pointer is carried into the opposite domain as a Gray code through a two-flop synchroniser. The half-full and almost-full flags are registered on the write clock. The almost-empty flag is registered on the read clock.

A mode input selects standard operation or first-word-fall-through operation. In fall-through mode the output register holds one more word, so the effective depth grows by one and every threshold moves up by one word. The almost-full and almost-empty offsets are inputs that are expected to stay static while the FIFO runs.

Top module: `dcflag_status`

## Requirements
- R1: While reset is low, half_full_n and almost_full_n read 1 and almost_empty_n reads 0.
- R2: almost_full_n is 0 exactly when occupancy >= E - af_ofs, where E = DEPTH with fwft_mode=0 and E = DEPTH+1 with fwft_mode=1. Otherwise it is 1, so it releases at one word below that level.
- R3: almost_empty_n is 0 exactly when occupancy <= ae_ofs with fwft_mode=0, or when occupancy <= ae_ofs+1 with fwft_mode=1.
- R4: half_full_n is 0 exactly when occupancy >= floor(DEPTH/2)+1 with fwft_mode=0, or when occupancy >= floor(DEPTH/2)+2 with fwft_mode=1.
- R5: Occupancy is (wr_ptr - rd_ptr) modulo 2^PW, so the flags stay correct when the pointers wrap.
- R6: A change of wr_ptr shows on half_full_n and almost_full_n after exactly one rising edge of wr_clk.
- R7: A rd_ptr change reaches the write-clock flags within 6 wr_clk cycles, and never after only one edge. A wr_ptr change reaches almost_empty_n within 6 rd_clk cycles.
- R8: When both pointers advance by the same amount, occupancy stays the same, and an asserted almost_full_n stays 0 throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| fwft_mode | input | 1 | 1 = first-word-fall-through thresholds, 0 = standard |
| af_ofs | input | OW | Almost-full offset |
| ae_ofs | input | OW | Almost-empty offset |
| wr_ptr | input | PW | Binary write pointer, wr_clk domain |
| rd_ptr | input | PW | Binary read pointer, rd_clk domain |
| half_full_n | output | 1 | Half-full flag, active low, wr_clk domain |
| almost_full_n | output | 1 | Almost-full flag, active low, wr_clk domain |
| almost_empty_n | output | 1 | Almost-empty flag, active low, rd_clk domain |

## Verification
On the write side, a local write-pointer step and a synchronised read-pointer step can land on the same wr_clk edge. The two moves then partly or wholly cancel in the occupancy sum. The bench provokes this by advancing both pointers together by one word on each of several cycles while almost-full is asserted. The skewed synchroniser makes the read update arrive a few edges after the write update, and the flag is judged at every write-clock cycle: it must never release, because the true occupancy never drops below the threshold.

// File: rtl/dcflag_pkg.sv
`timescale 1ns/1ps
package dcflag_pkg;

  // Binary to reflected Gray code.
  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // Gray back to binary: prefix XOR from the top bit down.
  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b = g;
    b = b ^ (b >> 1);
    b = b ^ (b >> 2);
    b = b ^ (b >> 4);
    b = b ^ (b >> 8);
    b = b ^ (b >> 16);
    return b;
  endfunction

  // Words held, modulo the pointer range of pw bits.
  function automatic logic [31:0] occupancy(input logic [31:0] w,
                                            input logic [31:0] r,
                                            input int unsigned pw);
    return (w - r) & ((32'd1 << pw) - 32'd1);
  endfunction

  // Depth seen by the flag logic: one extra word sits in the output stage.
  function automatic logic [31:0] eff_depth(input logic [31:0] depth,
                                            input logic fwft);
    return depth + {31'd0, fwft};
  endfunction

  // Occupancy at or above which almost-full is active.
  function automatic logic [31:0] af_level(input logic [31:0] depth,
                                           input logic fwft,
                                           input logic [31:0] ofs);
    return eff_depth(depth, fwft) - ofs;
  endfunction

  // Occupancy at or above which half-full is active.
  function automatic logic [31:0] hf_level(input logic [31:0] depth,
                                           input logic fwft);
    return (depth >> 1) + 32'd1 + {31'd0, fwft};
  endfunction

  // Occupancy at or below which almost-empty is active.
  function automatic logic [31:0] ae_level(input logic fwft,
                                           input logic [31:0] ofs);
    return ofs + {31'd0, fwft};
  endfunction

endpackage

// File: rtl/dcflag_ptr_sync.sv
`timescale 1ns/1ps
module dcflag_ptr_sync
  import dcflag_pkg::*;
#(
  parameter int PW     = 8,
  parameter int STAGES = 2
) (
  input  logic          src_clk,
  input  logic          dst_clk,
  input  logic          rst_n,
  input  logic [PW-1:0] src_bin,
  output logic [PW-1:0] dst_bin
);

  // Gray register in the source domain: only one bit moves per unit step.
  logic [PW-1:0] src_gray;
  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) src_gray <= '0;
    else        src_gray <= PW'(bin2gray(32'(src_bin)));
  end

  // Flop chain in the destination domain.
  logic [STAGES-1:0][PW-1:0] chain_q;
  always_ff @(posedge dst_clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], src_gray};
  end

  // Named wire for the last synchronised Gray value.
  logic [PW-1:0] gray_synced;
  assign gray_synced = chain_q[STAGES-1];
  assign dst_bin     = PW'(gray2bin(32'(gray_synced)));

  // R7: the synchronised value only moves to the value the stage before it held.
  assert_sync_follows_R7: assert property (@(posedge dst_clk) disable iff (!rst_n)
    (gray_synced != $past(gray_synced)) |-> (gray_synced == $past(chain_q[STAGES-2])));

endmodule

// File: rtl/dcflag_wr_flags.sv
`timescale 1ns/1ps
module dcflag_wr_flags
  import dcflag_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int PW    = 8,
  parameter int OW    = 6
) (
  input  logic          wr_clk,
  input  logic          rst_n,
  input  logic          fwft,
  input  logic [OW-1:0] af_ofs,
  input  logic [PW-1:0] wptr,
  input  logic [PW-1:0] rptr_s,
  output logic          hf_n,
  output logic          af_n
);

  localparam logic [31:0] DEPTH_W = 32'(DEPTH);

  // Arithmetic brought out as named wires.
  logic [31:0] occ_w;
  logic [31:0] af_lvl;
  logic [31:0] hf_lvl;
  logic        af_hit;
  logic        hf_hit;

  assign occ_w  = occupancy(32'(wptr), 32'(rptr_s), PW);
  assign af_lvl = af_level(DEPTH_W, fwft, 32'(af_ofs));
  assign hf_lvl = hf_level(DEPTH_W, fwft);
  assign af_hit = (occ_w >= af_lvl);
  assign hf_hit = (occ_w >= hf_lvl);

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      hf_n <= 1'b1;
      af_n <= 1'b1;
    end else begin
      hf_n <= ~hf_hit;
      af_n <= ~af_hit;
    end
  end

  assert_af_set_R2: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (occ_w >= af_lvl) |=> !af_n);

  assert_af_clear_R2: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (occ_w < af_lvl) |=> af_n);

  assert_hf_level_R4: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (occ_w < hf_lvl) |=> hf_n);

  // R4: with static settings, an active almost-full above the half level implies half-full.
  assert_af_implies_hf_R4: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (!af_n && $stable(fwft) && $stable(af_ofs) && (af_lvl >= hf_lvl)) |-> !hf_n);

endmodule

// File: rtl/dcflag_rd_flags.sv
`timescale 1ns/1ps
module dcflag_rd_flags
  import dcflag_pkg::*;
#(
  parameter int PW = 8,
  parameter int OW = 6
) (
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          fwft,
  input  logic [OW-1:0] ae_ofs,
  input  logic [PW-1:0] rptr,
  input  logic [PW-1:0] wptr_s,
  output logic          ae_n
);

  logic [31:0] occ_r;
  logic [31:0] ae_lvl;
  logic        ae_hit;

  assign occ_r  = occupancy(32'(wptr_s), 32'(rptr), PW);
  assign ae_lvl = ae_level(fwft, 32'(ae_ofs));
  assign ae_hit = (occ_r <= ae_lvl);

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) ae_n <= 1'b0;
    else        ae_n <= ~ae_hit;
  end

  assert_ae_set_R3: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (occ_r <= ae_lvl) |=> !ae_n);

  assert_ae_clear_R3: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (occ_r > ae_lvl) |=> ae_n);

endmodule

// File: rtl/dcflag_status.sv
`timescale 1ns/1ps
module dcflag_status #(
  parameter int DEPTH       = 64,
  parameter int PW          = $clog2(DEPTH + 2) + 1,
  parameter int OW          = $clog2(DEPTH),
  parameter int SYNC_STAGES = 2
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          fwft_mode,
  input  logic [OW-1:0] af_ofs,
  input  logic [OW-1:0] ae_ofs,
  input  logic [PW-1:0] wr_ptr,
  input  logic [PW-1:0] rd_ptr,
  output logic          half_full_n,
  output logic          almost_full_n,
  output logic          almost_empty_n
);

  logic [PW-1:0] rptr_in_wdom;
  logic [PW-1:0] wptr_in_rdom;

  dcflag_ptr_sync #(.PW(PW), .STAGES(SYNC_STAGES)) u_rd2wr (
    .src_clk (rd_clk),
    .dst_clk (wr_clk),
    .rst_n   (rst_n),
    .src_bin (rd_ptr),
    .dst_bin (rptr_in_wdom)
  );

  dcflag_ptr_sync #(.PW(PW), .STAGES(SYNC_STAGES)) u_wr2rd (
    .src_clk (wr_clk),
    .dst_clk (rd_clk),
    .rst_n   (rst_n),
    .src_bin (wr_ptr),
    .dst_bin (wptr_in_rdom)
  );

  dcflag_wr_flags #(.DEPTH(DEPTH), .PW(PW), .OW(OW)) u_wflags (
    .wr_clk (wr_clk),
    .rst_n  (rst_n),
    .fwft   (fwft_mode),
    .af_ofs (af_ofs),
    .wptr   (wr_ptr),
    .rptr_s (rptr_in_wdom),
    .hf_n   (half_full_n),
    .af_n   (almost_full_n)
  );

  dcflag_rd_flags #(.PW(PW), .OW(OW)) u_rflags (
    .rd_clk (rd_clk),
    .rst_n  (rst_n),
    .fwft   (fwft_mode),
    .ae_ofs (ae_ofs),
    .rptr   (rd_ptr),
    .wptr_s (wptr_in_rdom),
    .ae_n   (almost_empty_n)
  );

endmodule

// File: tb/dcflag_status_tb.sv
`timescale 1ns/1ps
module dcflag_status_tb;

  localparam int D  = 64;
  localparam int PW = 8;
  localparam int OW = 6;
  localparam int NV = 21;

  logic wr_clk = 1'b0;
  logic rd_clk = 1'b0;
  logic rst_n  = 1'b0;
  logic fwft_mode = 1'b0;
  logic [OW-1:0] af_ofs = '0;
  logic [OW-1:0] ae_ofs = '0;
  logic [PW-1:0] wr_ptr = '0;
  logic [PW-1:0] rd_ptr = '0;
  logic half_full_n, almost_full_n, almost_empty_n;

  always #10 wr_clk = ~wr_clk;
  always #15 rd_clk = ~rd_clk;

  dcflag_status #(.DEPTH(D)) u_dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .fwft_mode(fwft_mode), .af_ofs(af_ofs), .ae_ofs(ae_ofs),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .half_full_n(half_full_n), .almost_full_n(almost_full_n),
    .almost_empty_n(almost_empty_n)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input string what, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
    end
  endtask

  // {fwft, af_ofs, ae_ofs, rd_ptr, occupancy, exp hf_n, exp af_n, exp ae_n}
  // DEPTH 64: std AF >= 64-m, HF >= 33, AE <= n ; fwft AF >= 65-m, HF >= 34, AE <= n+1
  localparam logic [31:0] VT [NV] = '{
    {1'b0, 6'd8,  6'd4,  8'd100, 8'd0,  3'b110},
    {1'b0, 6'd8,  6'd4,  8'd100, 8'd4,  3'b110},
    {1'b0, 6'd8,  6'd4,  8'd100, 8'd5,  3'b111},
    {1'b1, 6'd8,  6'd4,  8'd100, 8'd5,  3'b110},
    {1'b1, 6'd8,  6'd4,  8'd100, 8'd6,  3'b111},
    {1'b0, 6'd8,  6'd4,  8'd100, 8'd32, 3'b111},
    {1'b0, 6'd8,  6'd4,  8'd100, 8'd33, 3'b011},
    {1'b1, 6'd8,  6'd4,  8'd100, 8'd33, 3'b111},
    {1'b1, 6'd8,  6'd4,  8'd100, 8'd34, 3'b011},
    {1'b0, 6'd8,  6'd4,  8'd100, 8'd55, 3'b011},
    {1'b0, 6'd8,  6'd4,  8'd100, 8'd56, 3'b001},
    {1'b1, 6'd8,  6'd4,  8'd100, 8'd56, 3'b011},
    {1'b1, 6'd8,  6'd4,  8'd100, 8'd57, 3'b001},
    {1'b1, 6'd8,  6'd4,  8'd100, 8'd65, 3'b001},
    {1'b0, 6'd8,  6'd4,  8'd250, 8'd64, 3'b001},
    {1'b0, 6'd0,  6'd0,  8'd100, 8'd64, 3'b001},
    {1'b0, 6'd0,  6'd0,  8'd100, 8'd63, 3'b011},
    {1'b0, 6'd0,  6'd0,  8'd250, 8'd0,  3'b110},
    {1'b0, 6'd20, 6'd10, 8'd200, 8'd44, 3'b001},
    {1'b0, 6'd20, 6'd10, 8'd200, 8'd10, 3'b110},
    {1'b1, 6'd20, 6'd10, 8'd200, 8'd11, 3'b110}
  };

  task automatic settle();
    repeat (10) @(negedge rd_clk);
    @(negedge wr_clk);
  endtask

  task automatic apply(input logic f, input int m, input int n, input int rp, input int occ);
    @(negedge wr_clk);
    fwft_mode = f;
    af_ofs = OW'(m);
    ae_ofs = OW'(n);
    rd_ptr = PW'(rp);
    wr_ptr = PW'(rp + occ);
    settle();
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int cnt;
    logic seen;

    // R1: reset values
    repeat (3) @(negedge wr_clk);
    chk("R1 half_full_n in reset", half_full_n, 1'b1);
    chk("R1 almost_full_n in reset", almost_full_n, 1'b1);
    @(negedge rd_clk);
    chk("R1 almost_empty_n in reset", almost_empty_n, 1'b0);
    @(negedge wr_clk);
    rst_n = 1'b1;

    // Vector table: R2 (af), R3 (ae), R4 (hf), R5 (wrapped pointers)
    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      string tag;
      v = VT[i];
      apply(v[31], int'(v[30:25]), int'(v[24:19]), int'(v[18:11]), int'(v[10:3]));
      tag = (v[18:11] == 8'd250) ? " R5 wrap" : "";
      chk($sformatf("R4 hf vec %0d%s", i, tag), half_full_n, v[2]);
      chk($sformatf("R2 af vec %0d%s", i, tag), almost_full_n, v[1]);
      @(negedge rd_clk);
      chk($sformatf("R3 ae vec %0d%s", i, tag), almost_empty_n, v[0]);
    end

    // R6: one write step crossing the almost-full level
    apply(1'b0, 8, 4, 100, 55);
    chk("R6 af before step", almost_full_n, 1'b1);
    @(negedge wr_clk);
    wr_ptr = wr_ptr + 1'b1;
    #1;
    chk("R6 af unchanged before edge", almost_full_n, 1'b1);
    @(negedge wr_clk);
    chk("R6 af one edge later", almost_full_n, 1'b0);

    // R7: read step releases almost-full through the synchroniser
    settle();
    @(negedge wr_clk);
    rd_ptr = rd_ptr + 1'b1;
    @(negedge wr_clk);
    chk("R7 af not released after one edge", almost_full_n, 1'b0);
    seen = 1'b0;
    cnt = 0;
    while (!seen && cnt < 5) begin
      @(negedge wr_clk);
      cnt++;
      if (almost_full_n) seen = 1'b1;
    end
    chk("R7 af released within window", seen, 1'b1);

    // R7: write step releases almost-empty through the synchroniser
    apply(1'b0, 8, 4, 100, 4);
    chk("R7 ae asserted at level", almost_empty_n, 1'b0);
    @(negedge wr_clk);
    wr_ptr = wr_ptr + 1'b1;
    seen = 1'b0;
    cnt = 0;
    while (!seen && cnt < 6) begin
      @(negedge rd_clk);
      cnt++;
      if (almost_empty_n) seen = 1'b1;
    end
    chk("R7 ae released within window", seen, 1'b1);

    // R8: both pointers advance together while almost-full is active
    apply(1'b0, 8, 4, 100, 56);
    chk("R8 af asserted at start", almost_full_n, 1'b0);
    for (int k = 0; k < 8; k++) begin
      @(negedge wr_clk);
      wr_ptr = wr_ptr + 1'b1;
      rd_ptr = rd_ptr + 1'b1;
      @(negedge wr_clk);
      chk($sformatf("R8 af held step %0d", k), almost_full_n, 1'b0);
    end
    settle();
    chk("R8 af held after settle", almost_full_n, 1'b0);

    finish_run();
  end

endmodule